// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block turns characters from a show-ahead transmit FIFO into asynchronous serial frames. Each frame has a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The data field is 7 or 8 bits wide. Parity can be off, odd or even. The line sits high when no frame is being sent. An external single-cycle baud tick sets every bit boundary, so each bit lasts exactly one tick interval.

Flow control is optional. When it is enabled, an active-low clear-to-send input passes through a two-flop synchronizer, and the transmitter looks at it only when a new frame could begin. A frame that has started always runs to its last stop bit. When flow control is disabled, the clear-to-send input has no effect.

The format inputs are captured at the moment a frame is launched and stay fixed until that frame ends.

Top module: `uart_cts_tx`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `fifo_pop` is 0.
- R2: A frame starts only on a cycle with `baud_tick` high while the FIFO is non-empty. On that cycle `fifo_pop` pulses for exactly one clock, and from the next cycle `txd` is 0 (the start bit) and `busy` is 1.
- R3: After the start bit, the data bits go out least significant bit first. With `cfg_data8`=1 all 8 bits of `fifo_data` are sent. With `cfg_data8`=0 only bits 6:0 are sent and bit 7 is dropped.
- R4: With `cfg_par_en`=1 and `cfg_par_odd`=1, one parity bit follows the data. It is 0 when the sent data bits contain an odd number of ones, and 1 otherwise.
- R5: With `cfg_par_en`=1 and `cfg_par_odd`=0, the parity bit is 0 when the sent data bits contain an even number of ones, and 1 otherwise. With `cfg_par_en`=0 no parity bit is sent.
- R6: The frame ends with one high stop bit when `cfg_stop2`=0 and two when `cfg_stop2`=1.
- R7: `txd` changes only on the clock edge that samples `baud_tick` high, so every bit lasts one tick interval.
- R8: With `cfg_flow_en`=1, a frame is launched only when `cts_n`, after two synchronizing flops, is 0. While `cts_n` stays 1, no character is popped and the line stays idle.
- R9: If `cts_n` rises during a frame with flow control on, that frame completes with all its bits, and no further frame starts until `cts_n` is 0 again.
- R10: With `cfg_flow_en`=0, `cts_n` is ignored and frames are sent whenever the FIFO holds data.
- R11: `busy` is 1 from the first cycle of the start bit through the last stop bit. When the FIFO still holds data and sending is allowed, the next start bit follows the last stop bit directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Single-cycle pulse marking each bit boundary |
| cfg_data8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_flow_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| fifo_empty | input | 1 | Transmit FIFO is empty |
| fifo_data | input | 8 | Head character of the FIFO (show-ahead) |
| fifo_pop | output | 1 | Removes the head character from the FIFO |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame is on the line |

## Verification
On every cycle, the assertions check the idle line level, that the start bit is low when `busy` rises, that a pop happens only with data present and is followed by a start bit, that the line changes only on tick edges, and that no pop is made with flow control on while the synchronized clear-to-send is high. The contents of each frame can only be checked by the bench scoreboard, which decodes the line at mid-bit. That covers the bit order, the dropped eighth bit, the parity polarity and the stop-bit count. So does the way clear-to-send affects more than one frame: a frame that is allowed to finish after `cts_n` rises, a character held back in the FIFO, and `cts_n` being ignored when gating is off.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic data8;
    logic par_en;
    logic stop2;
  } tx_fmt_t;

endpackage

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = async_in;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], async_in};
    end
  endgenerate

  // Resets to 1 (not clear to send).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic          full_width,
  input  logic          odd,
  output logic          par_bit
);

  logic [DW-1:0] used;
  logic          ones_odd;

  always_comb begin
    used     = full_width ? data : {1'b0, data[DW-2:0]};
    ones_odd = ^used;
    // Odd mode: bit set when the count of ones is even.
    par_bit  = odd ? ~ones_odd : ones_odd;
  end

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          can_send,
  input  logic [DW-1:0] char_in,
  input  logic          par_in,
  input  tx_fmt_t       fmt_in,
  output logic          pop,
  output logic          txd,
  output logic          busy
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] N_FULL  = CW'(DW);
  localparam logic [CW-1:0] N_SHORT = CW'(DW - 1);

  tx_state_e     state_q, state_d;
  logic [DW-1:0] shreg_q, shreg_d;
  logic [CW-1:0] cnt_q,   cnt_d;
  logic          stop_q,  stop_d;
  logic          par_q,   par_d;
  tx_fmt_t       fmt_q,   fmt_d;
  logic          txd_q,   txd_d;
  logic [CW-1:0] nbits;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    stop_d  = stop_q;
    par_d   = par_q;
    fmt_d   = fmt_q;
    txd_d   = txd_q;
    pop     = 1'b0;
    nbits   = fmt_q.data8 ? N_FULL : N_SHORT;

    if (baud_tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (can_send) begin
            state_d = ST_START;
            txd_d   = 1'b0;
            shreg_d = char_in;
            par_d   = par_in;
            fmt_d   = fmt_in;
            pop     = 1'b1;
          end
        end
        ST_START: begin
          state_d = ST_DATA;
          txd_d   = shreg_q[0];
          shreg_d = shreg_q >> 1;
          cnt_d   = CW'(1);
        end
        ST_DATA: begin
          if (cnt_q == nbits) begin
            if (fmt_q.par_en) begin
              state_d = ST_PAR;
              txd_d   = par_q;
            end else begin
              state_d = ST_STOP;
              txd_d   = 1'b1;
              stop_d  = 1'b0;
            end
          end else begin
            txd_d   = shreg_q[0];
            shreg_d = shreg_q >> 1;
            cnt_d   = cnt_q + CW'(1);
          end
        end
        ST_PAR: begin
          state_d = ST_STOP;
          txd_d   = 1'b1;
          stop_d  = 1'b0;
        end
        ST_STOP: begin
          if (fmt_q.stop2 && !stop_q) begin
            stop_d = 1'b1;
          end else if (can_send) begin
            state_d = ST_START;
            txd_d   = 1'b0;
            shreg_d = char_in;
            par_d   = par_in;
            fmt_d   = fmt_in;
            pop     = 1'b1;
          end else begin
            state_d = ST_IDLE;
            txd_d   = 1'b1;
          end
        end
        default: begin
          state_d = ST_IDLE;
          txd_d   = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      stop_q  <= 1'b0;
      par_q   <= 1'b0;
      fmt_q   <= '0;
      txd_q   <= 1'b1;
    end else if (baud_tick) begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      stop_q  <= stop_d;
      par_q   <= par_d;
      fmt_q   <= fmt_d;
      txd_q   <= txd_d;
    end
  end

  assign txd  = txd_q;
  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_tx_pkg::*;
#(
  parameter int DW         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          cfg_data8,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_stop2,
  input  logic          cfg_flow_en,
  input  logic          cts_n,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_pop,
  output logic          txd,
  output logic          busy
);

  logic    cts_n_s;
  logic    par_bit;
  logic    can_send;
  tx_fmt_t fmt;

  uart_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cts_n),
    .sync_out (cts_n_s)
  );

  uart_tx_parity #(.DW(DW)) u_par (
    .data       (fifo_data),
    .full_width (cfg_data8),
    .odd        (cfg_par_odd),
    .par_bit    (par_bit)
  );

  always_comb begin
    fmt.data8  = cfg_data8;
    fmt.par_en = cfg_par_en;
    fmt.stop2  = cfg_stop2;
    can_send   = !fifo_empty && (!cfg_flow_en || !cts_n_s);
  end

  uart_tx_engine #(.DW(DW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .can_send  (can_send),
    .char_in   (fifo_data),
    .par_in    (par_bit),
    .fmt_in    (fmt),
    .pop       (fifo_pop),
    .txd       (txd),
    .busy      (busy)
  );

endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic cfg_flow_en,
  input logic cts_n,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic txd,
  input logic busy
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  p_start_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (!fifo_empty && baud_tick));

  p_pop_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> (busy && !txd));

  p_tick_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));

  p_cts_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && cfg_flow_en) |-> !$past(cts_n, 2));

endmodule

bind uart_cts_tx uart_cts_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .baud_tick   (baud_tick),
  .cfg_flow_en (cfg_flow_en),
  .cts_n       (cts_n),
  .fifo_empty  (fifo_empty),
  .fifo_pop    (fifo_pop),
  .txd         (txd),
  .busy        (busy)
);

// File: tb/tb_uart_cts_tx.sv
module tb_uart_cts_tx;

  logic clk = 1'b0;
  logic rst_n;
  logic baud_tick;
  logic cfg_data8, cfg_par_en, cfg_par_odd, cfg_stop2, cfg_flow_en;
  logic cts_n;
  logic fifo_empty;
  logic [7:0] fifo_data;
  logic fifo_pop, txd, busy;

  always #5 clk = ~clk;

  uart_cts_tx dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_data8(cfg_data8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cfg_flow_en(cfg_flow_en), .cts_n(cts_n),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .txd(txd), .busy(busy)
  );

  int n_vec = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Baud tick: one cycle in every 8.
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt      <= (tcnt == 7) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == 7);
  end
  logic tick_seen = 1'b0;
  always @(posedge clk) tick_seen <= baud_tick;

  // FIFO model.
  logic [7:0] mem [64];
  int wr = 0;
  int rd = 0;
  assign fifo_empty = (wr == rd);
  assign fifo_data  = mem[rd % 64];
  always @(posedge clk) if (fifo_pop) rd <= rd + 1;

  typedef struct { logic [7:0] d; logic p; } exp_t;
  exp_t expq[$];

  function automatic logic exp_par(logic [7:0] d, logic d8, logic odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (i < 7 || d8) ones += d[i];
    return odd ? ((ones % 2 == 1) ? 1'b0 : 1'b1) : ((ones % 2 == 0) ? 1'b0 : 1'b1);
  endfunction

  task automatic push(input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    e.d = cfg_data8 ? d : {1'b0, d[6:0]};
    e.p = exp_par(d, cfg_data8, cfg_par_odd);
    expq.push_back(e);
    mem[wr % 64] = d;
    wr++;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!(wr == rd && !busy && txd)) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic set_fmt(input logic d8, input logic pe, input logic po, input logic s2);
    @(negedge clk);
    cfg_data8 = d8; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
  endtask

  // Monitor: decode the line at mid-bit and compare with the scoreboard.
  initial begin
    logic [7:0] got;
    logic       pb;
    int         nb;
    exp_t       e;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        chk(tick_seen === 1'b1, "R7 start on tick edge", tick_seen, 1);
        repeat (3) @(negedge clk);
        chk(txd === 1'b0, "R2 start bit", txd, 0);
        chk(busy === 1'b1, "R11 busy in start", busy, 1);
        nb  = cfg_data8 ? 8 : 7;
        got = '0;
        for (int i = 0; i < nb; i++) begin
          repeat (8) @(negedge clk);
          got[i] = txd;
        end
        pb = 1'b0;
        if (cfg_par_en) begin
          repeat (8) @(negedge clk);
          pb = txd;
        end
        for (int s = 0; s < (cfg_stop2 ? 2 : 1); s++) begin
          repeat (8) @(negedge clk);
          chk(txd === 1'b1, "R6 stop bit high", txd, 1);
          chk(busy === 1'b1, "R11 busy in stop", busy, 1);
        end
        if (expq.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", got, 0);
        end else begin
          e = expq.pop_front();
          chk(got == e.d, "R3 data bits", got, e.d);
          if (cfg_par_en)
            chk(pb == e.p, cfg_par_odd ? "R4 odd parity" : "R5 even parity", pb, e.p);
        end
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_vec++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_data8 = 1; cfg_par_en = 0; cfg_par_odd = 0; cfg_stop2 = 0;
    cfg_flow_en = 0; cts_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd === 1'b1 && busy === 1'b0 && fifo_pop === 1'b0, "R1 reset state",
        {txd, busy, fifo_pop}, 3'b100);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(txd === 1'b1 && busy === 1'b0, "R1 idle after reset", {txd, busy}, 2'b10);

    // 8N1, back to back; R10 cts_n high but gating off.
    push(8'h55); push(8'hA3); push(8'h00); push(8'hFF);
    drain();
    chk(wr == rd, "R10 fifo drained with cts ignored", wr - rd, 0);

    // 7E1: bit 7 dropped (R3, R5).
    set_fmt(0, 1, 0, 0);
    push(8'hFF); push(8'h35); push(8'h80);
    drain();

    // 8O2 (R4, R6).
    set_fmt(1, 1, 1, 1);
    push(8'h01); push(8'h7E); push(8'hC3);
    drain();

    // 7O1 and 8E2.
    set_fmt(0, 1, 1, 0);
    push(8'h2A); push(8'hF0);
    drain();
    set_fmt(1, 1, 0, 1);
    push(8'h96); push(8'h11);
    drain();
    chk(txd === 1'b1 && busy === 1'b0, "R1 idle between bursts", {txd, busy}, 2'b10);

    // R8: gating on, cts high blocks.
    set_fmt(1, 0, 0, 0);
    cfg_flow_en = 1'b1;
    cts_n = 1'b1;
    push(8'h5A);
    repeat (120) @(negedge clk);
    chk(busy === 1'b0 && txd === 1'b1, "R8 no frame while cts high", {busy, txd}, 2'b01);
    chk(wr - rd == 1, "R8 character held", wr - rd, 1);
    cts_n = 1'b0;
    drain();

    // R9: cts rises mid-frame.
    push(8'hC5); push(8'h3C);
    @(negedge clk);
    while (!busy) @(negedge clk);
    repeat (20) @(negedge clk);
    cts_n = 1'b1;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (120) @(negedge clk);
    chk(busy === 1'b0 && txd === 1'b1, "R9 no next frame", {busy, txd}, 2'b01);
    chk(wr - rd == 1, "R9 second character held", wr - rd, 1);
    chk(expq.size() == 1, "R9 first frame complete", expq.size(), 1);
    cts_n = 1'b0;
    drain();

    chk(expq.size() == 0, "R11 all frames seen", expq.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule